// File: doc/BRIEF.md
# Accumulator CPU Step Sequencer

This block is the control unit of a small accumulator processor. It walks every instruction through the same eight steps: four fetch steps followed by four execute steps. In each step it drives the strobes that steer the datapath: the address source select, memory read and write, instruction-register load, accumulator load, program-counter increment and load, the accumulator-to-bus drive, and halt. The 3-bit opcode comes from the instruction register. The zero flag from the ALU qualifies the conditional skip.

The strobes are a combinational decode of the current step and the opcode class. Only the step and a frozen flag are held in registers. Reset is synchronous and active-high. While reset is high every strobe is held low. The step returns to the first fetch step, and the strobes for that step appear in the first cycle after reset is released. A halt instruction raises halt in the first execute step. From then on the sequencer stays where it is, with only halt asserted, until the next reset.

Top module: `acc_cpu_sequencer`

## Requirements
- R1: While `rst` is high, every output is 0. After `rst` falls, the next cycle is the first fetch step. A reset in the middle of an instruction restarts the sequence.
- R2: In the four fetch steps (cycles 0 to 3 of an instruction), `addr_sel` is 1. `mem_rd` is 1 in cycles 1, 2 and 3. `ir_ld` is 1 in cycles 2 and 3. No other output is 1 in these cycles.
- R3: In cycle 4, `addr_sel` is 0 and `pc_inc` is 1. `halt` is also 1 when the opcode is 000 (halt). No other output is 1.
- R4: For opcodes 010, 011, 100 and 101 (add, and, xor, load), `mem_rd` is 1 in cycles 5, 6 and 7, and `acc_ld` is 1 in cycles 6 and 7.
- R5: For opcode 001 (skip if zero), `pc_inc` is 1 in cycle 6 only when `zero` is 1. Otherwise cycles 5 to 7 assert nothing.
- R6: For opcode 111 (jump), `pc_ld` is 1 in cycles 6 and 7, and in no other cycle.
- R7: For opcode 110 (store), `acc_drive` is 1 in cycles 6 and 7, and `mem_wr` is 1 in cycle 7 only. `mem_wr` is never 1 unless `acc_drive` is also 1.
- R8: After cycle 7 the sequence wraps, and the next cycle is cycle 0 of the next instruction.
- R9: After halt is raised, the sequence stops advancing. `halt` stays 1, every other output stays 0, and changes on `opcode` or `zero` have no effect until reset.
- R10: `zero` has no effect for any opcode other than 001, and no effect in any cycle other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 3 | Opcode of the instruction held in the instruction register |
| zero | input | 1 | ALU zero flag (accumulator equals zero) |
| addr_sel | output | 1 | 1 selects the program counter as memory address; 0 selects the operand field |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction-register load |
| acc_ld | output | 1 | Accumulator load |
| pc_inc | output | 1 | Program-counter increment |
| pc_ld | output | 1 | Program-counter load from the operand |
| acc_drive | output | 1 | Drive the accumulator onto the data bus |
| halt | output | 1 | Processor halted |

## Verification
All outputs are combinational functions of the registered step, so a result belongs to the same cycle in which its step is current. A change on `rst`, `opcode` or `zero` shows up at once, with no register in the path. The step advances one position per rising edge. The bench drives inputs on the falling edge, samples 1 ns later, and then lets exactly one rising edge pass. Cycle k after reset release is therefore sampled as step k. For every opcode and both values of the zero flag, the bench compares all nine outputs against a vector computed from the requirements in all eight steps and in the step that follows the wrap. It then holds a halted sequencer for several cycles and changes the inputs while it is frozen.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    localparam int OPC_W   = 3;
    localparam int STEPS   = 8;
    localparam int STEP_W  = $clog2(STEPS);

    typedef enum logic [STEP_W-1:0] {
        ST_IADDR  = 3'd0,
        ST_IFETCH = 3'd1,
        ST_ILOAD  = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_OADDR  = 3'd4,
        ST_OFETCH = 3'd5,
        ST_EXEC   = 3'd6,
        ST_WBACK  = 3'd7
    } step_e;

    localparam logic [OPC_W-1:0] OP_HALT  = 3'd0;
    localparam logic [OPC_W-1:0] OP_SKIPZ = 3'd1;
    localparam logic [OPC_W-1:0] OP_ADD   = 3'd2;
    localparam logic [OPC_W-1:0] OP_AND   = 3'd3;
    localparam logic [OPC_W-1:0] OP_XOR   = 3'd4;
    localparam logic [OPC_W-1:0] OP_LOAD  = 3'd5;
    localparam logic [OPC_W-1:0] OP_STORE = 3'd6;
    localparam logic [OPC_W-1:0] OP_JUMP  = 3'd7;

    typedef struct packed {
        logic halt;
        logic skipz;
        logic alu;
        logic store;
        logic jump;
    } opclass_t;

    typedef struct packed {
        logic addr_sel;
        logic mem_rd;
        logic mem_wr;
        logic ir_ld;
        logic acc_ld;
        logic pc_inc;
        logic pc_ld;
        logic acc_drive;
        logic halt;
    } ctl_t;

    typedef struct packed {
        step_e step;
        logic  frozen;
    } core_t;

endpackage

// File: rtl/seqctl_opclass.sv
module seqctl_opclass
    import seqctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output opclass_t         cls_o
);
    always_comb begin
        cls_o = '0;
        unique case (opcode_i)
            OP_HALT:  cls_o.halt  = 1'b1;
            OP_SKIPZ: cls_o.skipz = 1'b1;
            OP_ADD,
            OP_AND,
            OP_XOR,
            OP_LOAD:  cls_o.alu   = 1'b1;
            OP_STORE: cls_o.store = 1'b1;
            OP_JUMP:  cls_o.jump  = 1'b1;
            default:  cls_o = '0;
        endcase
    end
endmodule

// File: rtl/seqctl_next.sv
module seqctl_next
    import seqctl_pkg::*;
(
    input  step_e step_i,
    output step_e step_o
);
    logic [STEP_W-1:0] inc;

    always_comb begin
        inc    = step_i + STEP_W'(1);
        step_o = step_e'(inc);
    end
endmodule

// File: rtl/seqctl_decode.sv
module seqctl_decode
    import seqctl_pkg::*;
(
    input  step_e    step_i,
    input  opclass_t cls_i,
    input  logic     zero_i,
    output ctl_t     ctl_o
);
    logic fetch_ph;
    logic late_ex;

    always_comb begin
        fetch_ph = (step_i == ST_IADDR) || (step_i == ST_IFETCH) ||
                   (step_i == ST_ILOAD) || (step_i == ST_IWAIT);
        late_ex  = (step_i == ST_EXEC) || (step_i == ST_WBACK);

        ctl_o          = '0;
        ctl_o.addr_sel = fetch_ph;
        ctl_o.mem_rd   = (fetch_ph && step_i != ST_IADDR) ||
                         (cls_i.alu && (late_ex || step_i == ST_OFETCH));
        ctl_o.ir_ld    = (step_i == ST_ILOAD) || (step_i == ST_IWAIT);
        ctl_o.acc_ld   = cls_i.alu && late_ex;
        ctl_o.pc_inc   = (step_i == ST_OADDR) ||
                         (cls_i.skipz && zero_i && step_i == ST_EXEC);
        ctl_o.pc_ld    = cls_i.jump && late_ex;
        ctl_o.acc_drive = cls_i.store && late_ex;
        ctl_o.mem_wr   = cls_i.store && (step_i == ST_WBACK);
        ctl_o.halt     = cls_i.halt && (step_i == ST_OADDR);
    end
endmodule

// File: rtl/acc_cpu_sequencer.sv
module acc_cpu_sequencer
    import seqctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             zero,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_ld,
    output logic             acc_ld,
    output logic             pc_inc,
    output logic             pc_ld,
    output logic             acc_drive,
    output logic             halt
);
    core_t    core_d, core_q;
    opclass_t cls;
    step_e    step_nx;
    ctl_t     ctl_raw, ctl;

    seqctl_opclass u_cls (
        .opcode_i (opcode),
        .cls_o    (cls)
    );

    seqctl_next u_next (
        .step_i (core_q.step),
        .step_o (step_nx)
    );

    seqctl_decode u_dec (
        .step_i (core_q.step),
        .cls_i  (cls),
        .zero_i (zero),
        .ctl_o  (ctl_raw)
    );

    always_comb begin
        core_d = core_q;
        if (!core_q.frozen) begin
            if (core_q.step == ST_OADDR && cls.halt) begin
                core_d.frozen = 1'b1;
            end else begin
                core_d.step = step_nx;
            end
        end
        if (rst) begin
            core_d.step   = ST_IADDR;
            core_d.frozen = 1'b0;
        end

        if (rst) begin
            ctl = '0;
        end else if (core_q.frozen) begin
            ctl      = '0;
            ctl.halt = 1'b1;
        end else begin
            ctl = ctl_raw;
        end
    end

    always_ff @(posedge clk) begin
        core_q <= core_d;
    end

    assign addr_sel  = ctl.addr_sel;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign ir_ld     = ctl.ir_ld;
    assign acc_ld    = ctl.acc_ld;
    assign pc_inc    = ctl.pc_inc;
    assign pc_ld     = ctl.pc_ld;
    assign acc_drive = ctl.acc_drive;
    assign halt      = ctl.halt;
endmodule

// File: rtl/seqctl_checks.sv
module seqctl_checks (
    input logic clk,
    input logic rst,
    input logic addr_sel,
    input logic mem_rd,
    input logic mem_wr,
    input logic ir_ld,
    input logic acc_ld,
    input logic pc_inc,
    input logic pc_ld,
    input logic acc_drive,
    input logic halt
);
    always @(posedge clk) begin
        if (rst) begin
            a_r1_reset_quiet: assert ({addr_sel, mem_rd, mem_wr, ir_ld, acc_ld,
                                       pc_inc, pc_ld, acc_drive, halt} == 9'd0);
        end
    end

    a_r7_wr_needs_drive: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> acc_drive);

    a_r7_drive_precedes_wr: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(acc_drive));

    a_r4_acc_ld_reads: assert property (@(posedge clk) disable iff (rst)
        acc_ld |-> mem_rd);

    a_r3_sel_fall_incs: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_sel) |-> pc_inc);

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (halt && $past(halt)) |-> ({addr_sel, mem_rd, mem_wr, ir_ld, acc_ld,
                                    pc_inc, pc_ld, acc_drive} == 8'd0));

    a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind acc_cpu_sequencer seqctl_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_sel  (addr_sel),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ir_ld     (ir_ld),
    .acc_ld    (acc_ld),
    .pc_inc    (pc_inc),
    .pc_ld     (pc_ld),
    .acc_drive (acc_drive),
    .halt      (halt)
);

// File: tb/acc_cpu_sequencer_test.sv
module acc_cpu_sequencer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] opcode = 3'd0;
    logic       zero = 1'b0;
    logic addr_sel, mem_rd, mem_wr, ir_ld, acc_ld, pc_inc, pc_ld, acc_drive, halt;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    acc_cpu_sequencer uut (
        .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
        .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
        .acc_ld(acc_ld), .pc_inc(pc_inc), .pc_ld(pc_ld), .acc_drive(acc_drive),
        .halt(halt)
    );

    // vector order: {addr_sel, mem_rd, mem_wr, ir_ld, acc_ld, pc_inc, pc_ld, acc_drive, halt}
    function automatic logic [8:0] expect_vec(int op, bit z, int k);
        bit alu, skz, sto, jmp;
        logic [8:0] v;
        alu = (op >= 2) && (op <= 5);
        skz = (op == 1);
        sto = (op == 6);
        jmp = (op == 7);
        v[8] = (k < 4);
        v[7] = (k >= 1 && k <= 3) || (alu && k >= 5);
        v[6] = sto && (k == 7);
        v[5] = (k == 2) || (k == 3);
        v[4] = alu && (k >= 6);
        v[3] = (k == 4) || (skz && z && k == 6);
        v[2] = jmp && (k >= 6);
        v[1] = sto && (k >= 6);
        v[0] = (op == 0) && (k == 4);
        return v;
    endfunction

    function automatic logic [8:0] actual_vec();
        return {addr_sel, mem_rd, mem_wr, ir_ld, acc_ld, pc_inc, pc_ld, acc_drive, halt};
    endfunction

    task automatic check(string req, logic [8:0] exp);
        checks++;
        if (actual_vec() !== exp) begin
            bad++;
            $display("FAIL %s t=%0t op=%0d zero=%0b got=%b exp=%b",
                     req, $time, opcode, zero, actual_vec(), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1 check("R1", 9'd0);
        @(posedge clk);
        @(negedge clk);
        #1 check("R1", 9'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step_check(int op, bit z, int k, string req);
        opcode = 3'(op);
        zero   = z;
        #1 check(req, expect_vec(op, z, k));
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // exhaustive sweep: every opcode, both zero values, all steps and the wrap
        for (int op = 0; op < 8; op++) begin
            for (int z = 0; z < 2; z++) begin
                do_reset();
                if (op == 0) begin
                    for (int k = 0; k < 5; k++) step_check(op, z[0], k, k < 4 ? "R2" : "R3");
                    // frozen: halt only, input changes ignored (R9)
                    for (int h = 0; h < 5; h++) begin
                        opcode = 3'(h + 1);
                        zero   = h[0];
                        #1 check("R9", 9'b0_0000_0001);
                        @(negedge clk);
                    end
                end else begin
                    for (int k = 0; k < 9; k++) begin
                        string req;
                        if (k < 4)       req = "R2";
                        else if (k == 4) req = "R3";
                        else if (k == 8) req = "R8";
                        else if (op == 1) req = "R5";
                        else if (op == 6) req = "R7";
                        else if (op == 7) req = "R6";
                        else              req = "R4";
                        step_check(op, z[0], k % 8, req);
                    end
                end
            end
        end

        // back-to-back instructions with zero toggling outside the skip step (R10, R8)
        do_reset();
        for (int k = 0; k < 8; k++) step_check(2, k[0], k, "R10");
        for (int k = 0; k < 8; k++) step_check(1, (k != 6), k, "R10");
        for (int k = 0; k < 8; k++) step_check(6, k[1], k, "R8");

        // reset in the middle of an instruction restarts the sequence (R1)
        do_reset();
        for (int k = 0; k < 6; k++) step_check(3, 1'b0, k, "R4");
        rst = 1'b1;
        #1 check("R1", 9'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) step_check(3, 1'b0, k, "R1");

        // halted sequencer resumes only after reset (R9)
        do_reset();
        for (int k = 0; k < 5; k++) step_check(0, 1'b1, k, "R9");
        opcode = 3'd7;
        #1 check("R9", 9'b0_0000_0001);
        do_reset();
        for (int k = 0; k < 8; k++) step_check(7, 1'b0, k, "R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule